// File: doc/BRIEF.md
# MDIO Management Frame Master

This block turns a single management command into one complete serial transaction on a two-wire management bus. A command carries a read or write flag, a 5-bit register address and 16 bits of write data. When it is accepted, the block clocks out 96 bits, most significant bit first. The first 32 bits are all ones, the next 32 are the frame word, and the last 32 are all zeros. The PHY address is fixed inside the frame template. On a read, the block releases the data line during turnaround and the data field. It samples the 16 returned bits and publishes them in a status word.

The serial clock comes from the system clock through a divide-by-`CLK_DIV` counter and rests low between transactions. The data line changes only after a falling serial-clock edge. Incoming data is sampled on the rising edge. The status word has a busy flag, a sticky flag that records a command arriving while busy, and the most recent read result. Software polls the busy flag, then reads the result.

Top module: `mdio_frame_master`

## Requirements
- R1: A command with `cmdValid` high while idle is accepted at that clock edge. Status bit 31 (busy) reads 1 from the next cycle for exactly 96 × `CLK_DIV` cycles, then returns to 0.
- R2: `mdc` is low while idle. During a transaction it makes exactly 96 pulses. Each pulse is low for `CLK_DIV`/2 cycles, then high for `CLK_DIV`/2 cycles, starting with a low half right after acceptance.
- R3: The bit stream on `mdioOut`, sampled at each rising `mdc` edge, is 32 ones, then the 32-bit frame word MSB first, then 32 zeros. `mdioOut` never changes while `mdc` is high.
- R4: A write frame (`cmdIsRead`=0) equals 0x59020000 OR (address << 18) OR the 16-bit write data in bits 15:0.
- R5: A read frame (`cmdIsRead`=1) equals 0x69020000 OR (address << 18), with bits 15:0 zero.
- R6: `mdioOe` is 0 while idle. It is 1 for all 96 bits of a write. For a read it is 0 from frame bit 17 through frame bit 0 (stream bits 46 to 63, counting from 0 at the first preamble bit) and 1 for every other bit.
- R7: During a read, `mdioIn` is sampled at the rising `mdc` edge of frame bits 15 to 0, MSB first. The 16-bit result appears in status bits 15:0 in the cycle busy drops. Status bits 15:0 do not change during a transaction, or after a write.
- R8: A command presented while busy is ignored: the running stream is unaffected. It sets status bit 30 one cycle later. Bit 30 stays set until the next accepted command clears it.
- R9: After reset the status word is 0, `mdc` is 0, `mdioOe` is 0 and `mdioOut` is 0. Status bits 29:16 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdIsRead | input | 1 | 1 = read frame, 0 = write frame |
| cmdRegAddr | input | 5 | Target register address |
| cmdWrData | input | 16 | Data for a write frame |
| status | output | 32 | [31] busy, [30] sticky command-while-busy error, [15:0] last read result |
| mdc | output | 1 | Serial management clock |
| mdioOut | output | 1 | Serial data driven toward the pad |
| mdioOe | output | 1 | Output enable for the data pad driver |
| mdioIn | input | 1 | Serial data returned from the pad |

## Verification
A wrong phase or bit counter appears at the ports within one serial bit time. It shows as a missing or extra `mdc` pulse, a stream shifted against the expected 96-bit image, or a busy window of the wrong length. An enable decode that is off by one bit is caught at the first read, because the enable pattern is compared bit by bit. A fault in capture ordering or commit shows in status bits 15:0 as soon as busy drops. A fault in the sticky flag shows one cycle after the command that arrives while busy.

// File: rtl/mdio_fm_pkg.sv
package mdio_fm_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 3;
  localparam int CAP_W     = 16;
  localparam int ADDR_W    = 5;
  localparam int ADDR_LSB  = 18;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRE   = 2'd1,
    PH_FRAME = 2'd2,
    PH_TRAIL = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;       // command accepted this edge
    logic mdcRise;     // raise serial clock
    logic mdcFall;     // lower serial clock, advance a bit
    logic loadFrame;   // next word is the frame word
    logic loadTrail;   // next word is the zero trailer
    logic finish;      // last bit done
    logic sampleBit;   // capture mdioIn
    logic commitRead;  // publish captured data
    logic driveEn;     // pad output enable level
  } dpStrobes_t;

  function automatic logic [WORD_W-1:0] buildFrame(
    input logic [WORD_W-1:0] wrTmpl,
    input logic [WORD_W-1:0] rdTmpl,
    input logic              isRead,
    input logic [ADDR_W-1:0] addr,
    input logic [CAP_W-1:0]  data
  );
    logic [WORD_W-1:0] addrField;
    logic [WORD_W-1:0] dataField;
    addrField = WORD_W'(addr) << ADDR_LSB;
    dataField = isRead ? '0 : WORD_W'(data);
    return (isRead ? rdTmpl : wrTmpl) | addrField | dataField;
  endfunction

endpackage

// File: rtl/mdio_fm_ctrl.sv
module mdio_fm_ctrl
  import mdio_fm_pkg::*;
#(
  parameter int CLK_DIV = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdIsRead,
  output logic       busy,
  output logic       errFlag,
  output logic       curIsRead,
  output dpStrobes_t strb
);

  localparam int HALF      = CLK_DIV / 2;
  localparam int DIV_W     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W     = $clog2(WORD_W);
  // frame bit 17 sits at word position WORD_W-1-17
  localparam int OE_FROM   = WORD_W - 1 - (CAP_W + 1);
  localparam int DATA_FROM = WORD_W - CAP_W;

  phase_e           phase;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             accept;
  logic             halfHit;
  logic             fullHit;
  logic             lastBit;
  logic             inFrameRead;

  assign busy = (phase != PH_IDLE);

  always_comb begin
    accept      = cmdValid && !busy;
    halfHit     = busy && (divCnt == DIV_W'(HALF - 1));
    fullHit     = busy && (divCnt == DIV_W'(CLK_DIV - 1));
    lastBit     = (bitIdx == BIT_W'(WORD_W - 1));
    inFrameRead = (phase == PH_FRAME) && curIsRead;

    strb            = '0;
    strb.start      = accept;
    strb.mdcRise    = halfHit;
    strb.mdcFall    = fullHit;
    strb.loadFrame  = fullHit && lastBit && (phase == PH_PRE);
    strb.loadTrail  = fullHit && lastBit && (phase == PH_FRAME);
    strb.finish     = fullHit && lastBit && (phase == PH_TRAIL);
    strb.sampleBit  = halfHit && inFrameRead && (bitIdx >= BIT_W'(DATA_FROM));
    strb.commitRead = strb.finish && curIsRead;
    strb.driveEn    = busy && !(inFrameRead && (bitIdx >= BIT_W'(OE_FROM)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      divCnt    <= '0;
      bitIdx    <= '0;
      curIsRead <= 1'b0;
    end else if (accept) begin
      phase     <= PH_PRE;
      divCnt    <= '0;
      bitIdx    <= '0;
      curIsRead <= cmdIsRead;
    end else if (busy) begin
      divCnt <= fullHit ? '0 : divCnt + DIV_W'(1);
      if (fullHit) begin
        bitIdx <= lastBit ? '0 : bitIdx + BIT_W'(1);
        if (lastBit) begin
          unique case (phase)
            PH_PRE:   phase <= PH_FRAME;
            PH_FRAME: phase <= PH_TRAIL;
            default:  phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                errFlag <= 1'b0;
    else if (accept)          errFlag <= 1'b0;
    else if (cmdValid && busy) errFlag <= 1'b1;
  end

endmodule

// File: rtl/mdio_fm_dp.sv
module mdio_fm_dp
  import mdio_fm_pkg::*;
#(
  parameter logic [31:0] WR_TEMPLATE = 32'h5902_0000,
  parameter logic [31:0] RD_TEMPLATE = 32'h6902_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic              cmdIsRead,
  input  logic [ADDR_W-1:0] cmdRegAddr,
  input  logic [CAP_W-1:0]  cmdWrData,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic [CAP_W-1:0]  rdData
);

  logic [WORD_W-1:0] frameReg;
  logic [WORD_W-1:0] shiftReg;
  logic [CAP_W-1:0]  capShift;

  assign mdioOut = shiftReg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg <= '0;
      shiftReg <= '0;
      mdc      <= 1'b0;
    end else if (strb.start) begin
      frameReg <= buildFrame(WR_TEMPLATE, RD_TEMPLATE, cmdIsRead,
                             cmdRegAddr, cmdWrData);
      shiftReg <= '1;
      mdc      <= 1'b0;
    end else begin
      if (strb.mdcRise) mdc <= 1'b1;
      if (strb.mdcFall) begin
        mdc <= 1'b0;
        if (strb.loadFrame)                      shiftReg <= frameReg;
        else if (strb.loadTrail || strb.finish) shiftReg <= '0;
        else                                     shiftReg <= shiftReg << 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capShift <= '0;
      rdData   <= '0;
    end else begin
      if (strb.sampleBit)  capShift <= {capShift[CAP_W-2:0], mdioIn};
      if (strb.commitRead) rdData   <= capShift;
    end
  end

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_fm_pkg::*;
#(
  parameter int          CLK_DIV     = 16,
  parameter logic [31:0] WR_TEMPLATE = 32'h5902_0000,
  parameter logic [31:0] RD_TEMPLATE = 32'h6902_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdIsRead,
  input  logic [4:0]  cmdRegAddr,
  input  logic [15:0] cmdWrData,
  output logic [31:0] status,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  dpStrobes_t       strb;
  logic             busy;
  logic             errFlag;
  logic             curIsRead;
  logic [CAP_W-1:0] rdData;

  mdio_fm_ctrl #(
    .CLK_DIV(CLK_DIV)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdIsRead (cmdIsRead),
    .busy      (busy),
    .errFlag   (errFlag),
    .curIsRead (curIsRead),
    .strb      (strb)
  );

  mdio_fm_dp #(
    .WR_TEMPLATE(WR_TEMPLATE),
    .RD_TEMPLATE(RD_TEMPLATE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmdIsRead  (cmdIsRead),
    .cmdRegAddr (cmdRegAddr),
    .cmdWrData  (cmdWrData),
    .mdioIn     (mdioIn),
    .mdc        (mdc),
    .mdioOut    (mdioOut),
    .rdData     (rdData)
  );

  assign mdioOe = strb.driveEn;
  assign status = {busy, errFlag, 14'b0, rdData};

endmodule

// File: rtl/mdio_fm_checker.sv
module mdio_fm_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [31:0] status,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        curIsRead
);

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !status[31] |-> !mdc); // R2

  AST_RISE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> status[31]); // R2

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut)); // R3

  AST_IDLE_OE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !status[31] |-> !mdioOe); // R6

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (status[31] && !curIsRead) |-> mdioOe); // R6

  AST_RDATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (status[31] && $past(status[31])) |-> $stable(status[15:0])); // R7

  AST_ERR_ON_BUSY_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (status[31] && cmdValid) |=> status[30]); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (status[30] && !(cmdValid && !status[31])) |=> status[30]); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    status[29:16] == 14'd0); // R9

endmodule

bind mdio_frame_master mdio_fm_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .status    (status),
  .mdc       (mdc),
  .mdioOut   (mdioOut),
  .mdioOe    (mdioOe),
  .curIsRead (curIsRead)
);

// File: tb/mdio_frame_master_tb.sv
module mdio_frame_master_tb;

  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdIsRead = 1'b0;
  logic [4:0]  cmdRegAddr = '0;
  logic [15:0] cmdWrData = '0;
  logic [31:0] status;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn = 1'b1;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  logic [15:0] lastRead = '0;

  always #2 clk = ~clk;  // 250 MHz

  mdio_frame_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsRead(cmdIsRead),
    .cmdRegAddr(cmdRegAddr), .cmdWrData(cmdWrData), .status(status),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic check(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic phyBit(input int idx, input logic [15:0] v);
    if (idx >= 48 && idx <= 63) return v[63-idx];
    return 1'b1;
  endfunction

  task automatic doXfer(input logic isRd, input logic [4:0] addr,
                        input logic [15:0] wd, input logic [15:0] rv,
                        input bit injErr);
    logic [31:0] frame;
    logic [95:0] expBits, gotBits, expOe, gotOe;
    int bitIdx = 0, busyCyc = 0, mdcHigh = 0, highChg = 0, holdBad = 0, guard = 0;
    logic prevMdc = 1'b0, riseVal = 1'b0;
    logic [15:0] expRd;
    frame   = (isRd ? 32'h6902_0000 : 32'h5902_0000) | (32'(addr) << 18)
              | (isRd ? 32'h0 : 32'(wd));
    expBits = {32'hFFFF_FFFF, frame, 32'h0};
    expOe   = isRd ? ~(96'h3FFFF << 32) : '1;
    gotBits = '0;
    gotOe   = '0;
    @(negedge clk);
    cmdValid = 1'b1; cmdIsRead = isRd; cmdRegAddr = addr; cmdWrData = wd;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdRegAddr = ~addr; cmdWrData = ~wd; cmdIsRead = ~isRd;
    // R1 R8: busy visible, error cleared by the accepted command
    check(status[31] == 1'b1 && status[30] == 1'b0, "R1/R8 accept", 96'(status[31:30]), 96'h2);
    mdioIn = phyBit(0, rv);
    while (status[31] && guard < 2000) begin
      guard++;
      busyCyc++;
      if (status[15:0] !== lastRead) holdBad++;
      if (mdc) begin
        mdcHigh++;
        if (!prevMdc) begin
          riseVal = mdioOut;
          gotBits[95-bitIdx] = mdioOut;
          gotOe[95-bitIdx]   = mdioOe;
          bitIdx++;
          mdioIn = phyBit(bitIdx, rv);
        end else if (mdioOut !== riseVal) highChg++;
      end
      prevMdc = mdc;
      cmdValid = (injErr && busyCyc == 50);
      @(negedge clk);
    end
    cmdValid = 1'b0;
    expRd = isRd ? rv : lastRead;
    check(busyCyc == 96*DIV, "R1 busy length", 96'(busyCyc), 96'(96*DIV));
    check(bitIdx == 96 && mdcHigh == 96*HALF, "R2 mdc pulses",
          96'(bitIdx), 96'(96));
    check(mdc == 1'b0, "R2 mdc idle low", 96'(mdc), 96'h0);
    check(gotBits == expBits, isRd ? "R3/R5 read stream" : "R3/R4 write stream",
          gotBits, expBits);
    check(highChg == 0, "R3 mdio stable while mdc high", 96'(highChg), 96'h0);
    check(gotOe == expOe, "R6 output enable pattern", gotOe, expOe);
    check(mdioOe == 1'b0, "R6 oe idle", 96'(mdioOe), 96'h0);
    check(holdBad == 0, "R7 data held during transfer", 96'(holdBad), 96'h0);
    check(status[15:0] == expRd, "R7 read result", 96'(status[15:0]), 96'(expRd));
    check(status[30] == injErr, "R8 sticky error", 96'(status[30]), 96'(injErr));
    check(status[29:16] == 14'd0, "R9 reserved bits", 96'(status[29:16]), 96'h0);
    lastRead = expRd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status == 32'h0 && mdc == 1'b0 && mdioOe == 1'b0 && mdioOut == 1'b0,
          "R9 reset state", 96'({status, mdc, mdioOe, mdioOut}), 96'h0);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 32; a++) begin
      for (int op = 0; op < 2; op++) begin
        logic [15:0] wd, rv;
        wd = 16'(a * 16'h0841) ^ 16'hA5C3;
        rv = {a[4:0], ~a[4:0], 6'(a * 3)} ^ 16'h3C96;
        doXfer(op[0], a[4:0], wd, rv, (a % 7) == 3);
      end
    end
    // boundary patterns: all ones / all zeros data and address
    doXfer(1'b0, 5'h1F, 16'hFFFF, 16'h0000, 1'b0);
    doXfer(1'b1, 5'h00, 16'h0000, 16'hFFFF, 1'b1);
    doXfer(1'b1, 5'h1F, 16'h0000, 16'h0001, 1'b0);
    doXfer(1'b0, 5'h00, 16'h0000, 16'h8000, 1'b0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule